// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog. Software writes its registers over a plain register port: an address, a write strobe and 32 bits of write data, with the read data driven combinationally from the same address. A write takes effect only when bits 31:16 of the data hold the constant key 0x1234, and only bits 15:0 carry a value. The port accepts a transfer on every cycle and has no back-pressure. There is no valid/ready stream here, because the block moves no data.

The slow timer clock arrives as a one-cycle enable pulse, `tmr_tick`. A prescaler divides it by a programmable amount, and each prescaled step moves a 16-bit down-counter. When the count runs out, the counter reloads and raises a sticky interrupt. If it runs out a second time before software refreshes the counter, the block pulses a reset request for one clock.

Software services the watchdog through a refresh register that holds three two-bit groups. Flipping a group between codes 1 and 2 triggers one of three actions: adopting the new configuration, reloading the counter, or clearing the interrupt. New divisor and load values are used only after their group has been flipped.

Top module: `guarded_wdog`

## Requirements
- R1: A write whose bits 31:16 differ from 0x1234 changes no register.
- R2: A write with the wrong key sets bit 0 of the status register at offset 0x0. The bit stays set until a write with the correct key puts a 1 in bit 0 at offset 0x0.
- R3: A read returns the stored 16-bit value in bits 15:0 and zero in bits 31:16. The register offsets are: configuration 0x4 (divisor minus one in bits 15:8), load 0x8, refresh 0x18 and start 0x1C (bit 0 is the enable). The values after reset are 0x0F00, 0xFFFF, 0x0015 and 0x0000.
- R4: With an active divisor field d, the counter moves one step for every d+1 pulses of `tmr_tick`.
- R5: With an active load L, where L of 0 behaves as 1, the counter runs out after L steps and reloads from the active load.
- R6: The first run-out sets `irq`, and `irq` stays set.
- R7: A second run-out without an intervening counter refresh drives `rst_req` high for exactly one clock.
- R8: A refresh group acts only when a write with the correct key changes it from 1 to 2 or from 2 to 1. Any other transition has no effect.
- R9: Flipping bits 5:4 adopts the stored divisor and clears the prescaler. Flipping bits 3:2 adopts the stored load, reloads the counter and rearms the first-run-out state. Until these groups are flipped, the previously adopted values stay in use.
- R10: Flipping bits 1:0 clears `irq`.
- R11: While start bit 0 is clear, the prescaler and the counter hold their values, and neither `irq` nor `rst_req` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | One-cycle pulse per timer clock period |
| bus_addr | input | 5 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: key in 31:16, value in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Sticky timeout interrupt |
| rst_req | output | 1 | One-clock reset request |

## Verification
The embedded assertions check the following on every cycle:
- a write with the wrong key leaves all registers unchanged and flags the error;
- the prescaler count never exceeds the active divisor;
- `irq` stays set until it is cleared;
- `rst_req` appears only when the block is already armed;
- a stopped block holds its count.

Only the directed scenarios can show the exact timing from enable to the first run-out, the effect of the divisor on that timing, the use of the old load value after the load register has been rewritten, and which refresh-code transitions are ignored. Each of these is measured by counting clocks at the ports.

// File: rtl/guarded_wdog_pkg.sv
package guarded_wdog_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned VAL_W   = 16;
  localparam int unsigned ADDR_W  = 5;
  localparam logic [15:0] WR_KEY  = 16'h1234;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RFSH  = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_START = 5'h1C;

  localparam int unsigned N_GRP = 3;
  localparam int unsigned GRP_INT = 0;
  localparam int unsigned GRP_CNT = 1;
  localparam int unsigned GRP_CFG = 2;

  localparam logic [VAL_W-1:0] CFG_RST  = 16'h0F00;
  localparam logic [VAL_W-1:0] LOAD_RST = 16'hFFFF;
  localparam logic [VAL_W-1:0] RFSH_RST = 16'h0015;
endpackage

// File: rtl/gw_regfile.sv
module gw_regfile
  import guarded_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic [7:0]        act_div_o,
  output logic [VAL_W-1:0]  act_load_o,
  output logic [VAL_W-1:0]  load_raw_o,
  output logic              div_rl_o,
  output logic              cnt_rl_o,
  output logic              irq_clr_o
);
  logic [VAL_W-1:0] cfg_q, load_q, rfsh_q, start_q, act_load_q;
  logic [7:0]       act_div_q;
  logic             err_q;
  logic             key_ok, wr_ok, rf_wr;
  logic [N_GRP-1:0] flip;

  assign key_ok = (wdata_i[DATA_W-1:VAL_W] == WR_KEY);
  assign wr_ok  = wr_i && key_ok;
  assign rf_wr  = wr_ok && (addr_i == OFS_RFSH);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [1:0] was, now;
    assign was = rfsh_q[2*g+1:2*g];
    assign now = wdata_i[2*g+1:2*g];
    assign flip[g] = rf_wr && (((was == 2'd1) && (now == 2'd2)) ||
                               ((was == 2'd2) && (now == 2'd1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RST;
      load_q     <= LOAD_RST;
      rfsh_q     <= RFSH_RST;
      start_q    <= '0;
      err_q      <= 1'b0;
      act_div_q  <= CFG_RST[15:8];
      act_load_q <= LOAD_RST;
    end else begin
      if (wr_i && !key_ok) err_q <= 1'b1;
      if (wr_ok) begin
        case (addr_i)
          OFS_STAT:  if (wdata_i[0]) err_q <= 1'b0;
          OFS_CFG:   cfg_q   <= wdata_i[VAL_W-1:0];
          OFS_LOAD:  load_q  <= wdata_i[VAL_W-1:0];
          OFS_RFSH:  rfsh_q  <= wdata_i[VAL_W-1:0];
          OFS_START: start_q <= wdata_i[VAL_W-1:0];
          default: ;
        endcase
      end
      if (flip[GRP_CFG]) act_div_q  <= cfg_q[15:8];
      if (flip[GRP_CNT]) act_load_q <= load_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_STAT:  rdata_o[0]         = err_q;
      OFS_CFG:   rdata_o[VAL_W-1:0] = cfg_q;
      OFS_LOAD:  rdata_o[VAL_W-1:0] = load_q;
      OFS_RFSH:  rdata_o[VAL_W-1:0] = rfsh_q;
      OFS_START: rdata_o[VAL_W-1:0] = start_q;
      default: ;
    endcase
  end

  assign run_o      = start_q[0];
  assign act_div_o  = act_div_q;
  assign act_load_o = act_load_q;
  assign load_raw_o = load_q;
  assign div_rl_o   = flip[GRP_CFG];
  assign cnt_rl_o   = flip[GRP_CNT];
  assign irq_clr_o  = flip[GRP_INT];

  // R1: a write with the wrong key leaves the registers unchanged
  p_bad_key_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !key_ok) |=> ($stable(cfg_q) && $stable(load_q) &&
                           $stable(rfsh_q) && $stable(start_q)));
  // R2: a write with the wrong key leaves the error flag set
  p_err_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !key_ok) |=> err_q);
endmodule

// File: rtl/gw_prescaler.sv
module gw_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  output logic             step_o
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q == div_i);
  assign step_o = run_i && tick_i && wrap && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clr_i)            pre_q <= '0;
    else if (run_i && tick_i)  pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  // R4: the prescaler count stays within the active divisor
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= div_i);
  // R11: a stopped prescaler holds its count
  p_pre_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/gw_counter.sv
module gw_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] act_load_i,
  input  logic             irq_clr_i,
  output logic             irq_o,
  output logic             rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, rst_q, armed_q, expire;

  assign expire = run_i && step_i && !reload_i && (cnt_q <= 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= {CNT_W{1'b1}};
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      rst_q <= expire && armed_q;
      if (reload_i) begin
        cnt_q   <= reload_val_i;
        armed_q <= 1'b0;
      end else if (run_i && step_i) begin
        if (expire) begin
          cnt_q   <= act_load_i;
          armed_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (expire)         irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
  assign rst_o = rst_q;

  // R6: the interrupt stays set until it is cleared
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr_i) |=> irq_q);
  // R7: a reset request needs an earlier run-out
  p_rst_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> $past(armed_q));
  // R11: a stopped counter holds its value and raises no reset request
  p_cnt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> ($stable(cnt_q) && !rst_q));
endmodule

// File: rtl/guarded_wdog.sv
module guarded_wdog
  import guarded_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic             run, div_rl, cnt_rl, irq_clr, step;
  logic [7:0]       act_div;
  logic [VAL_W-1:0] act_load, load_raw;

  gw_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .run_o(run),
    .act_div_o(act_div), .act_load_o(act_load), .load_raw_o(load_raw),
    .div_rl_o(div_rl), .cnt_rl_o(cnt_rl), .irq_clr_o(irq_clr)
  );

  gw_prescaler #(.DIV_W(8)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tmr_tick),
    .div_i(act_div), .clr_i(div_rl), .step_o(step)
  );

  gw_counter #(.CNT_W(VAL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(step),
    .reload_i(cnt_rl), .reload_val_i(load_raw), .act_load_i(act_load),
    .irq_clr_i(irq_clr), .irq_o(irq), .rst_o(rst_req)
  );

  // R11: no interrupt is raised while stopped
  p_irq_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run));
endmodule

// File: tb/guarded_wdog_tb.sv
module guarded_wdog_tb;
  logic        clk = 0, rst_n = 0, tmr_tick = 1, bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq, rst_req;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] rf = 16'h0015;

  always #5 clk = ~clk;

  guarded_wdog u_dut (.clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] v, logic [15:0] key = 16'h1234);
    @(negedge clk);
    bus_addr = a; bus_wdata = {key, v}; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; #1;
    v = bus_rdata;
  endtask

  task automatic wait_sig(bit use_rst, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!(use_rst ? rst_req : irq) && n < 3000);
  endtask

  task automatic fresh(logic [15:0] load, logic [7:0] d);
    wr(5'h1C, 16'h0);
    wr(5'h04, {d, 8'h00});
    wr(5'h08, load);
    rf = rf ^ 16'h003F;
    wr(5'h18, rf);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h04, v); chk("R3 cfg reset", v, 32'h0F00);
    rd(5'h08, v); chk("R3 load reset", v, 32'hFFFF);
    rd(5'h18, v); chk("R3 refresh reset", v, 32'h0015);
    rd(5'h1C, v); chk("R3 start reset", v, 32'h0);
    chk("R6 irq reset", irq, 0);
    chk("R7 rst_req reset", rst_req, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(5'h08, 16'h00AA, 16'h1235);
    rd(5'h08, v); chk("R1 load unchanged by bad key", v, 32'hFFFF);
    wr(5'h1C, 16'h0001, 16'h0000);
    rd(5'h1C, v); chk("R1 start unchanged by bad key", v, 32'h0);
    rd(5'h00, v); chk("R2 key error set", v, 32'h1);
    wr(5'h00, 16'h0001, 16'hFFFF);
    rd(5'h00, v); chk("R2 clear needs key", v, 32'h1);
    wr(5'h00, 16'h0001);
    rd(5'h00, v); chk("R2 key error cleared", v, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    wr(5'h08, 16'hABCD);
    rd(5'h08, v); chk("R3 upper half reads zero", v, 32'h0000ABCD);
  endtask

  task automatic t_basic();
    int n;
    fresh(16'd5, 8'd0);
    wr(5'h1C, 16'h1);
    wait_sig(0, n); chk("R5 first run-out after 5 steps", n, 5);
    chk("R7 no reset on first run-out", rst_req, 0);
    wait_sig(1, n); chk("R7 second run-out after 5 more", n, 5);
    chk("R6 irq still set", irq, 1);
    @(posedge clk); #1; chk("R7 reset is one clock", rst_req, 0);
  endtask

  task automatic t_prescale();
    int n;
    fresh(16'd4, 8'd2);
    chk("R10 irq cleared by refresh", irq, 0);
    wr(5'h1C, 16'h1);
    wait_sig(0, n); chk("R4 divisor 3 gives 12 clocks", n, 12);
  endtask

  task automatic t_latched();
    int n;
    fresh(16'd7, 8'd0);
    wr(5'h08, 16'd2);
    wr(5'h04, 16'h0500);
    wr(5'h1C, 16'h1);
    wait_sig(0, n); chk("R9 old divisor and load in use", n, 7);
    wait_sig(1, n); chk("R9 reload uses adopted load", n, 7);
  endtask

  task automatic t_codes();
    logic [31:0] v;
    wr(5'h1C, 16'h0);
    chk("R6 irq set before code test", irq, 1);
    rf = (rf & 16'hFFFC) | 16'h3;
    wr(5'h18, rf);
    chk("R8 move to code 3 ignored", irq, 1);
    rf = (rf & 16'hFFFC) | 16'h2;
    wr(5'h18, rf);
    chk("R8 move from code 3 ignored", irq, 1);
    rf = (rf & 16'hFFFC) | 16'h1;
    wr(5'h18, rf);
    chk("R10 irq cleared by 2 to 1", irq, 0);
    rd(5'h18, v); chk("R3 refresh readback", v, {16'h0, rf});
  endtask

  task automatic t_hold();
    int n;
    fresh(16'd3, 8'd1);
    wr(5'h1C, 16'h1);
    repeat (2) @(posedge clk);
    wr(5'h1C, 16'h0);
    repeat (40) @(posedge clk);
    #1;
    chk("R11 no irq while stopped", irq, 0);
    chk("R11 no reset while stopped", rst_req, 0);
    wr(5'h1C, 16'h1);
    wait_sig(0, n); chk("R11 count resumed where held", n, 3);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_key();
    t_read();
    t_basic();
    t_prescale();
    t_latched();
    t_codes();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule